// File: doc/BRIEF.md
# SPI Register Access Port

This block is a serial slave that lets an external controller read and write a bank of 8-bit configuration registers. A transfer is framed by an active-low chip select. During the transfer the controller clocks in an address byte and then a data byte, both most significant bit first. Bit 7 of the address byte picks the direction: 1 for a read, 0 for a write. The lower seven bits name the register. For a write, the data byte is forwarded to the register file once the whole frame has arrived. For a read, the register is fetched as soon as the address byte is complete, and its contents are shifted back on the serial output during the data byte of the same frame.

The serial pins are not treated as clocks. Serial clock, chip select and serial input are brought into a system clock through two-flop synchronizers, and serial clock edges are found by comparing successive samples. The system clock must run at least 8 times as fast as the serial clock. The serial output comes as a data bit plus an output enable, so a pad can float the line whenever the enable is low.

Top module: `spi_regport`

## Requirements
- R1: A frame is 8 address bits followed by 8 data bits, each sent most significant bit first and sampled on rising serial-clock edges. Address bit 7 = 0 marks a write, and address bits 6..0 select the register. A complete write frame puts the data byte on `rf_wdata` and the 7-bit index on `rf_addr`.
- R2: A write frame raises `rf_we` for exactly one system cycle, only after the 16th rising edge, and once per frame.
- R3: A write frame cut short by chip select rising before the 16th rising edge produces no `rf_we` pulse.
- R4: A frame whose address bit 7 = 1 raises `rf_re` for one system cycle once the 8th rising edge has been seen. `rf_addr` holds the index while `rf_re` is high. It never produces `rf_we`.
- R5: In a read frame the register value captured at `rf_re` is launched on `sdo` from bit 7 down to bit 0, one bit per falling serial-clock edge of the data phase. Each bit is therefore stable at rising edges 9 through 16.
- R6: `sdo_oe` is low throughout the address phase. It is low whenever the synchronized chip select is high, and it falls within 3 system cycles of chip select rising.
- R7: Each new chip-select assertion restarts bit counting from zero, so a frame that follows an aborted frame is decoded correctly.
- R8: After reset, `sdo_oe`, `rf_we` and `rf_re` are low.
- R9: Rising edges after the 16th within one frame are ignored: there is no second write, and the committed data comes from the first 16 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sck | input | 1 | Serial clock, idles low |
| cs_n | input | 1 | Active-low chip select |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out bit |
| sdo_oe | output | 1 | Output enable for sdo; low means high impedance |
| rf_addr | output | 7 | Register index |
| rf_wdata | output | 8 | Write data |
| rf_we | output | 1 | One-cycle write strobe |
| rf_re | output | 1 | One-cycle read strobe |
| rf_rdata | input | 8 | Read data from the register file, combinational on rf_addr |

## Verification
Every result trails its pin stimulus by two synchronizer stages plus one edge-detect register, so an event lands 2 to 3 system cycles after the pin edge. The bench therefore moves pins only on falling system-clock edges. Each serial-clock phase lasts 8 system cycles, and `sdo` and `sdo_oe` are sampled 4 cycles into the high phase, well after a launched bit has settled. Strobes are counted on every rising system edge and compared per frame. The float check after chip select rises is taken exactly 3 cycles later.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int SPI_ADDR_W = 8;
  localparam int SPI_DATA_W = 8;

  function automatic logic f_is_read(input logic [SPI_ADDR_W-1:0] abyte);
    return abyte[SPI_ADDR_W-1];
  endfunction

  function automatic logic [SPI_ADDR_W-2:0] f_reg_idx(input logic [SPI_ADDR_W-1:0] abyte);
    return abyte[SPI_ADDR_W-2:0];
  endfunction
endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int W = 3,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= RST_VAL;
      else if (s == 0) stg[s] <= d;
      else stg[s] <= stg[(s == 0) ? 0 : s-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/spi_frame.sv
module spi_frame
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = SPI_ADDR_W,
  parameter int DATA_W = SPI_DATA_W,
  localparam int FRAME_BITS = ADDR_W + DATA_W,
  localparam int CNT_W = $clog2(FRAME_BITS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  output logic              sck_fall,
  output logic [CNT_W-1:0]  cnt,
  output logic              is_rd,
  output logic [ADDR_W-2:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re
);
  localparam int SH_W = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
  localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] ADDR_END   = CNT_W'(ADDR_W);

  logic            sck_q;
  logic            sck_rise;
  logic [SH_W-1:0] sh;
  logic [SH_W-1:0] sh_next;
  logic            addr_done;
  logic            frame_done;

  assign sck_rise   = sck_s & ~sck_q & ~cs_n_s;
  assign sck_fall   = ~sck_s & sck_q & ~cs_n_s;
  assign sh_next    = {sh[SH_W-2:0], sdi_s};
  assign addr_done  = sck_rise && (cnt == ADDR_LAST);
  assign frame_done = sck_rise && (cnt == FRAME_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q    <= 1'b0;
      cnt      <= '0;
      sh       <= '0;
      is_rd    <= 1'b0;
      rf_addr  <= '0;
      rf_wdata <= '0;
      rf_we    <= 1'b0;
      rf_re    <= 1'b0;
    end else begin
      sck_q <= sck_s;
      rf_we <= 1'b0;
      rf_re <= 1'b0;
      if (cs_n_s) begin
        cnt   <= '0;
        is_rd <= 1'b0;
      end else if (sck_rise && cnt < FRAME_END) begin
        sh  <= sh_next;
        cnt <= cnt + 1'b1;
        if (addr_done) begin
          rf_addr <= f_reg_idx(sh_next[ADDR_W-1:0]);
          is_rd   <= f_is_read(sh_next[ADDR_W-1:0]);
          rf_re   <= f_is_read(sh_next[ADDR_W-1:0]);
        end
        if (frame_done && !is_rd) begin
          rf_wdata <= sh_next[DATA_W-1:0];
          rf_we    <= 1'b1;
        end
      end
    end
  end

  p_we_at_end_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> (cnt == FRAME_END));
  p_we_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |=> !rf_we);
  p_re_at_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rf_re |-> (cnt == ADDR_END) && is_rd);
  p_we_re_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(rf_we && rf_re));
  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FRAME_END);
endmodule

// File: rtl/spi_sdo_drv.sv
module spi_sdo_drv #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_act,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              fall,
  input  logic              launch_ok,
  output logic              sdo,
  output logic              sdo_oe
);
  logic [DATA_W-1:0] sh;
  logic              launched;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh       <= '0;
      sdo      <= 1'b0;
      launched <= 1'b0;
    end else if (!frame_act) begin
      launched <= 1'b0;
    end else if (load) begin
      sh <= load_data;
    end else if (fall && launch_ok) begin
      sdo      <= sh[DATA_W-1];
      sh       <= {sh[DATA_W-2:0], 1'b0};
      launched <= 1'b1;
    end
  end

  assign sdo_oe = launched & frame_act;

  p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sdo_oe && !fall) |=> $stable(sdo));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int ADDR_W = SPI_ADDR_W,
  parameter int DATA_W = SPI_DATA_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sck,
  input  logic              cs_n,
  input  logic              sdi,
  output logic              sdo,
  output logic              sdo_oe,
  output logic [ADDR_W-2:0] rf_addr,
  output logic [DATA_W-1:0] rf_wdata,
  output logic              rf_we,
  output logic              rf_re,
  input  logic [DATA_W-1:0] rf_rdata
);
  localparam int FRAME_BITS = ADDR_W + DATA_W;
  localparam int CNT_W = $clog2(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] ADDR_END  = CNT_W'(ADDR_W);
  localparam logic [CNT_W-1:0] FRAME_END = CNT_W'(FRAME_BITS);

  logic [2:0]       pins_s;
  logic             sck_s, cs_n_s, sdi_s;
  logic             sck_fall;
  logic [CNT_W-1:0] cnt;
  logic             is_rd;
  logic             data_phase;

  spi_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck, cs_n, sdi}), .q(pins_s)
  );
  assign {sck_s, cs_n_s, sdi_s} = pins_s;

  spi_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .sck_s(sck_s), .cs_n_s(cs_n_s), .sdi_s(sdi_s),
    .sck_fall(sck_fall), .cnt(cnt), .is_rd(is_rd), .rf_addr(rf_addr),
    .rf_wdata(rf_wdata), .rf_we(rf_we), .rf_re(rf_re)
  );

  assign data_phase = is_rd && (cnt >= ADDR_END) && (cnt < FRAME_END);

  spi_sdo_drv #(.DATA_W(DATA_W)) u_sdo (
    .clk(clk), .rst_n(rst_n), .frame_act(~cs_n_s), .load(rf_re),
    .load_data(rf_rdata), .fall(sck_fall), .launch_ok(data_phase),
    .sdo(sdo), .sdo_oe(sdo_oe)
  );

  p_oe_data_phase_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sdo_oe |-> (cnt >= ADDR_END) && is_rd);
  p_oe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_s |-> !sdo_oe);
endmodule

// File: tb/sim_spi_regport.sv
module sim_spi_regport;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sck = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic sdo, sdo_oe, rf_we, rf_re;
  logic [6:0] rf_addr;
  logic [7:0] rf_wdata, rf_rdata;
  logic [7:0] regs [128];
  int checks = 0, fails = 0, we_cnt = 0, re_cnt = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_regport u0 (
    .clk(clk), .rst_n(rst_n), .sck(sck), .cs_n(cs_n), .sdi(sdi), .sdo(sdo),
    .sdo_oe(sdo_oe), .rf_addr(rf_addr), .rf_wdata(rf_wdata), .rf_we(rf_we),
    .rf_re(rf_re), .rf_rdata(rf_rdata)
  );

  assign rf_rdata = regs[rf_addr];

  always @(posedge clk) begin
    if (rf_we) begin
      regs[rf_addr] <= rf_wdata;
      we_cnt <= we_cnt + 1;
    end
    if (rf_re) re_cnt <= re_cnt + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // one frame of nbits; rd holds data-phase samples of sdo
  task automatic xfer(input logic [15:0] bits, input int nbits, output logic [7:0] rd,
                      output bit oe_addr, output bit oe_data_all, output bit oe_after);
    rd = '0; oe_addr = 0; oe_data_all = 1;
    @(negedge clk); cs_n = 1'b0;
    repeat (8) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi = (i < 16) ? bits[15-i] : 1'b0;
      repeat (8) @(negedge clk);
      sck = 1'b1;
      repeat (4) @(negedge clk);
      if (i < 8 && sdo_oe) oe_addr = 1;
      if (i >= 8 && i < 16) begin
        rd[15-i] = sdo;
        if (!sdo_oe) oe_data_all = 0;
      end
      repeat (4) @(negedge clk);
      sck = 1'b0;
    end
    repeat (8) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
    oe_after = sdo_oe;
    repeat (16) @(negedge clk);
  endtask

  // {rw, addr7, wdata8, exp8}
  localparam logic [23:0] VEC [9] = '{
    {1'b0, 7'h05, 8'hA5, 8'h00}, {1'b0, 7'h7F, 8'h3C, 8'h00},
    {1'b0, 7'h00, 8'h81, 8'h00}, {1'b1, 7'h05, 8'h00, 8'hA5},
    {1'b1, 7'h7F, 8'h00, 8'h3C}, {1'b1, 7'h00, 8'h00, 8'h81},
    {1'b0, 7'h05, 8'h5A, 8'h00}, {1'b1, 7'h05, 8'h00, 8'h5A},
    {1'b1, 7'h10, 8'h00, 8'h00}
  };

  initial begin
    logic [7:0] rd;
    bit oa, od, of;
    int w0, r0;
    for (int k = 0; k < 128; k++) regs[k] = 8'h00;
    repeat (4) @(negedge clk);
    chk(!sdo_oe && !rf_we && !rf_re, "R8 reset idle", {sdo_oe, rf_we, rf_re}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!sdo_oe && !rf_we && !rf_re, "R8 after release", {sdo_oe, rf_we, rf_re}, 0);

    for (int v = 0; v < 9; v++) begin
      w0 = we_cnt; r0 = re_cnt;
      xfer({VEC[v][23:16], VEC[v][15:8]}, 16, rd, oa, od, of);
      if (!VEC[v][23]) begin
        chk(regs[VEC[v][22:16]] == VEC[v][15:8], "R1 write data", regs[VEC[v][22:16]], VEC[v][15:8]);
        chk(we_cnt - w0 == 1 && re_cnt == r0, "R2 one write strobe", we_cnt - w0, 1);
        chk(!oa && !od ? 1'b1 : !oa, "R6 no drive on write", oa, 0);
      end else begin
        chk(rd == VEC[v][7:0], "R5 read data", rd, VEC[v][7:0]);
        chk(re_cnt - r0 == 1 && we_cnt == w0, "R4 one read strobe", re_cnt - r0, 1);
        chk(!oa, "R6 float in address phase", oa, 0);
        chk(od, "R5 driven in data phase", od, 1);
      end
      chk(!of, "R6 float 3 cycles after cs high", of, 0);
    end

    // R3: abort a write after 12 bits
    w0 = we_cnt;
    xfer({8'h05, 8'hFF}, 12, rd, oa, od, of);
    chk(we_cnt == w0, "R3 aborted write no strobe", we_cnt - w0, 0);
    // R7: next frame starts counting afresh
    xfer({8'h85, 8'h00}, 16, rd, oa, od, of);
    chk(rd == 8'h5A, "R7 frame after abort", rd, 8'h5A);
    w0 = we_cnt;
    xfer({8'h7F, 8'h00}, 3, rd, oa, od, of);
    chk(we_cnt == w0, "R3 short abort", we_cnt - w0, 0);
    xfer({8'hFF, 8'h00}, 16, rd, oa, od, of);
    chk(rd == 8'h3C, "R7 read after 3-bit abort", rd, 8'h3C);

    // R9: extra edges after 16 ignored
    w0 = we_cnt;
    xfer({8'h22, 8'hC3}, 19, rd, oa, od, of);
    chk(we_cnt - w0 == 1, "R9 single write with extra edges", we_cnt - w0, 1);
    chk(regs[7'h22] == 8'hC3, "R9 data from first 16 bits", regs[7'h22], 8'hC3);
    chk(rf_addr == 7'h22, "R1 index on rf_addr", rf_addr, 7'h22);
    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule